// File: doc/BRIEF.md
# PHY Loopback Path Controller

This block sits in the symbol-level datapath of a 10/100 Ethernet PHY and selects one of three paths. In normal operation, transmit symbols go to the line and symbols recovered from the line go to the PCS. In local loopback, the 5-bit transmit symbols are turned back into the receive path so the PCS sees its own traffic. In remote loopback, symbols recovered from the line are sent straight back out to the line encoder and driver.

Alongside the data path, the block owns three side-band outputs: the signal-detect output, the transmit driver enable (low means the driver is tristated) and a forced 10 Mb/s link indication that is shown to the link partner during local loopback. Two control bits request the loopback types. A 2-bit operating-mode input restricts remote loopback to 100BASE-TX. The active path changes only on a symbol-boundary strobe, so no partial symbol is ever forwarded.

Top module: `phy_lpbk_ctrl`

## Requirements
- R1: While rst_ni is low the path is normal, both symbol outputs are 0, drv_en_o is 1, link10_force_o is 0 and sd_o equals sd_line_i.
- R2: With no loopback active, each sym_tick_i edge loads pcs_rx_sym_o from line_rx_sym_i and line_tx_sym_o from tx_sym_i, sd_o follows sd_line_i, drv_en_o is 1 and link10_force_o is 0.
- R3: A local request (ctl_local_lpbk_i=1) sampled on a tick enters local loopback: pcs_rx_sym_o and line_tx_sym_o both load tx_sym_i, sd_o is forced to 1 and drv_en_o is 0.
- R4: In local loopback, link10_force_o is 1 while tx_en_i is 0 and drops to 0 in the same cycle tx_en_i is 1, returning when tx_en_i falls.
- R5: A remote request (ctl_remote_lpbk_i=1) with mode_i=2'b01 (100BASE-TX) on a tick enters remote loopback: both symbol outputs load line_rx_sym_i, sd_o is forced to 0, drv_en_o is 1 and link10_force_o is 0.
- R6: A remote request with mode_i of 2'b00 (10BASE-T), 2'b10 (100BASE-FX) or 2'b11 (reserved) is ignored, and the block behaves exactly as in R2.
- R7: When both requests are present on a tick, local loopback wins.
- R8: Requests and mode_i are sampled only on cycles with sym_tick_i=1. Between ticks the path, both symbol outputs, sd_o forcing and drv_en_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_tick_i | input | 1 | Symbol boundary strobe; path and symbols update here |
| ctl_local_lpbk_i | input | 1 | Local loopback request bit |
| ctl_remote_lpbk_i | input | 1 | Remote loopback request bit |
| mode_i | input | 2 | Operating mode: 00 10BASE-T, 01 100BASE-TX, 10 100BASE-FX, 11 reserved |
| tx_en_i | input | 1 | Packet transmission in progress |
| tx_sym_i | input | 5 | Transmit symbol from the encoder side |
| line_rx_sym_i | input | 5 | Symbol recovered from the line |
| sd_line_i | input | 1 | Signal detect from the line receiver |
| pcs_rx_sym_o | output | 5 | Receive symbol toward the PCS |
| line_tx_sym_o | output | 5 | Symbol toward the line encoder and driver |
| sd_o | output | 1 | Signal-detect output |
| drv_en_o | output | 1 | Line driver enable, 0 = tristated |
| link10_force_o | output | 1 | Forced 10 Mb/s link indication to the partner |

## Verification
The hardest case to reach from the ports is a request or a mode change that arrives between symbol boundaries. The path must not move until the next tick, even though the side-band outputs are otherwise combinational in their inputs. The bench raises a request, and separately pulls mode_i away from 100BASE-TX during remote loopback, while holding sym_tick_i low for several cycles. It confirms that drv_en_o, sd_o and both symbol outputs are frozen, and only then issues a tick. It also toggles tx_en_i inside local loopback without ticks to show the link indication follows transmission activity immediately.

// File: rtl/phy_lpbk_pkg.sv
package phy_lpbk_pkg;
  typedef enum logic [1:0] {
    LB_NONE   = 2'b00,
    LB_LOCAL  = 2'b01,
    LB_REMOTE = 2'b10
  } lb_path_e;

  localparam int unsigned MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_10T   = 2'b00;
  localparam logic [MODE_W-1:0] MODE_100TX = 2'b01;
  localparam logic [MODE_W-1:0] MODE_100FX = 2'b10;
endpackage

// File: rtl/lpbk_arbiter.sv
module lpbk_arbiter
  import phy_lpbk_pkg::*;
(
  input  logic              req_local_i,
  input  logic              req_remote_i,
  input  logic [MODE_W-1:0] mode_i,
  output lb_path_e          path_o
);
  always_comb begin
    if (req_local_i)                               path_o = LB_LOCAL;
    else if (req_remote_i && mode_i == MODE_100TX) path_o = LB_REMOTE;
    else                                           path_o = LB_NONE;
  end
endmodule

// File: rtl/lpbk_sym_path.sv
module lpbk_sym_path
  import phy_lpbk_pkg::*;
#(
  parameter int unsigned SYM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  lb_path_e         path_nxt_i,
  input  logic [SYM_W-1:0] tx_sym_i,
  input  logic [SYM_W-1:0] rx_sym_i,
  output lb_path_e         path_o,
  output logic [SYM_W-1:0] pcs_sym_o,
  output logic [SYM_W-1:0] line_sym_o
);
  lb_path_e         path_q;
  logic [SYM_W-1:0] pcs_q, line_q;
  logic [SYM_W-1:0] pcs_d, line_d;

  // symbols are chosen with the path that becomes active on this boundary
  always_comb begin
    pcs_d  = (path_nxt_i == LB_LOCAL)  ? tx_sym_i : rx_sym_i;
    line_d = (path_nxt_i == LB_REMOTE) ? rx_sym_i : tx_sym_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      path_q <= LB_NONE;
      pcs_q  <= '0;
      line_q <= '0;
    end else if (tick_i) begin
      path_q <= path_nxt_i;
      pcs_q  <= pcs_d;
      line_q <= line_d;
    end
  end

  assign path_o     = path_q;
  assign pcs_sym_o  = pcs_q;
  assign line_sym_o = line_q;
endmodule

// File: rtl/lpbk_sideband.sv
module lpbk_sideband
  import phy_lpbk_pkg::*;
(
  input  lb_path_e path_i,
  input  logic     sd_line_i,
  input  logic     tx_en_i,
  output logic     sd_o,
  output logic     drv_en_o,
  output logic     link10_force_o
);
  always_comb begin
    unique case (path_i)
      LB_LOCAL:  sd_o = 1'b1;
      LB_REMOTE: sd_o = 1'b0;
      default:   sd_o = sd_line_i;
    endcase
  end

  assign drv_en_o       = (path_i != LB_LOCAL);
  // partner sees the forced link only while no packet is being sent
  assign link10_force_o = (path_i == LB_LOCAL) && !tx_en_i;
endmodule

// File: rtl/phy_lpbk_ctrl.sv
module phy_lpbk_ctrl
  import phy_lpbk_pkg::*;
#(
  parameter int unsigned SYM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_tick_i,
  input  logic              ctl_local_lpbk_i,
  input  logic              ctl_remote_lpbk_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              tx_en_i,
  input  logic [SYM_W-1:0]  tx_sym_i,
  input  logic [SYM_W-1:0]  line_rx_sym_i,
  input  logic              sd_line_i,
  output logic [SYM_W-1:0]  pcs_rx_sym_o,
  output logic [SYM_W-1:0]  line_tx_sym_o,
  output logic              sd_o,
  output logic              drv_en_o,
  output logic              link10_force_o
);
  lb_path_e path_nxt, path_cur;

  lpbk_arbiter u_arb (
    .req_local_i  (ctl_local_lpbk_i),
    .req_remote_i (ctl_remote_lpbk_i),
    .mode_i       (mode_i),
    .path_o       (path_nxt)
  );

  lpbk_sym_path #(.SYM_W(SYM_W)) u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sym_tick_i),
    .path_nxt_i (path_nxt),
    .tx_sym_i   (tx_sym_i),
    .rx_sym_i   (line_rx_sym_i),
    .path_o     (path_cur),
    .pcs_sym_o  (pcs_rx_sym_o),
    .line_sym_o (line_tx_sym_o)
  );

  lpbk_sideband u_sb (
    .path_i         (path_cur),
    .sd_line_i      (sd_line_i),
    .tx_en_i        (tx_en_i),
    .sd_o           (sd_o),
    .drv_en_o       (drv_en_o),
    .link10_force_o (link10_force_o)
  );
endmodule

// File: rtl/phy_lpbk_ctrl_chk.sv
module phy_lpbk_ctrl_chk
  import phy_lpbk_pkg::*;
#(
  parameter int unsigned SYM_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sym_tick_i,
  input logic              ctl_local_lpbk_i,
  input logic              ctl_remote_lpbk_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              tx_en_i,
  input logic [SYM_W-1:0]  tx_sym_i,
  input logic [SYM_W-1:0]  line_rx_sym_i,
  input logic              sd_line_i,
  input logic [SYM_W-1:0]  pcs_rx_sym_o,
  input logic [SYM_W-1:0]  line_tx_sym_o,
  input logic              sd_o,
  input logic              drv_en_o,
  input logic              link10_force_o
);
  p_rst_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> drv_en_o && !link10_force_o && pcs_rx_sym_o == '0 && line_tx_sym_o == '0);

  p_hold_between_ticks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_tick_i |=> $stable(pcs_rx_sym_o) && $stable(line_tx_sym_o) && $stable(drv_en_o));

  p_local_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_tick_i && ctl_local_lpbk_i |=> !drv_en_o && sd_o && pcs_rx_sym_o == $past(tx_sym_i));

  p_drv_off_sd_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> sd_o);

  p_link_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link10_force_o |-> !tx_en_i && !drv_en_o);

  p_remote_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_tick_i && ctl_remote_lpbk_i && !ctl_local_lpbk_i && mode_i == MODE_100TX
    |=> !sd_o && drv_en_o && line_tx_sym_o == $past(line_rx_sym_i));

  p_remote_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_tick_i && !ctl_local_lpbk_i && mode_i != MODE_100TX
    |=> drv_en_o && !link10_force_o && line_tx_sym_o == $past(tx_sym_i)
        && pcs_rx_sym_o == $past(line_rx_sym_i));
endmodule

bind phy_lpbk_ctrl phy_lpbk_ctrl_chk #(.SYM_W(SYM_W)) chk_i (.*);

// File: tb/phy_lpbk_ctrl_tb_top.sv
module phy_lpbk_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sym_tick_i = 1'b0;
  logic       ctl_local_lpbk_i = 1'b0;
  logic       ctl_remote_lpbk_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       tx_en_i = 1'b0;
  logic [4:0] tx_sym_i = '0;
  logic [4:0] line_rx_sym_i = '0;
  logic       sd_line_i = 1'b1;
  logic [4:0] pcs_rx_sym_o, line_tx_sym_o;
  logic       sd_o, drv_en_o, link10_force_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  phy_lpbk_ctrl dut_i (.*);

  typedef struct packed {
    logic       loc;
    logic       rem;
    logic [1:0] mode;
    logic       txen;
    logic       sdl;
    logic [4:0] tx;
    logic [4:0] rx;
    logic [4:0] e_pcs;
    logic [4:0] e_line;
    logic       e_sd;
    logic       e_drv;
    logic       e_lnk;
  } vec_t;

  // R2 normal, R3/R4 local, R5 remote, R6 remote ignored, R7 priority
  localparam vec_t VECS [10] = '{
    '{1'b0,1'b0,2'b01,1'b0,1'b1,5'h0A,5'h15, 5'h15,5'h0A,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,2'b00,1'b0,1'b0,5'h03,5'h1C, 5'h1C,5'h03,1'b0,1'b1,1'b0},
    '{1'b1,1'b0,2'b00,1'b0,1'b0,5'h07,5'h18, 5'h07,5'h07,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,2'b01,1'b1,1'b0,5'h11,5'h0E, 5'h11,5'h11,1'b1,1'b0,1'b0},
    '{1'b0,1'b1,2'b01,1'b0,1'b1,5'h09,5'h16, 5'h16,5'h16,1'b0,1'b1,1'b0},
    '{1'b0,1'b1,2'b00,1'b0,1'b1,5'h0C,5'h13, 5'h13,5'h0C,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,2'b10,1'b0,1'b0,5'h1F,5'h01, 5'h01,5'h1F,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,2'b01,1'b0,1'b0,5'h05,5'h1A, 5'h05,5'h05,1'b1,1'b0,1'b1},
    '{1'b0,1'b1,2'b11,1'b0,1'b1,5'h02,5'h1D, 5'h1D,5'h02,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,2'b01,1'b0,1'b1,5'h14,5'h0B, 5'h0B,5'h14,1'b1,1'b1,1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [4:0] pcs, input logic [4:0] line,
                         input logic sd, input logic drv, input logic lnk);
    chk(req, "pcs_rx_sym",    pcs_rx_sym_o,           pcs);
    chk(req, "line_tx_sym",   line_tx_sym_o,          line);
    chk(req, "sd",            {4'b0, sd_o},           {4'b0, sd});
    chk(req, "drv_en",        {4'b0, drv_en_o},       {4'b0, drv});
    chk(req, "link10_force",  {4'b0, link10_force_o}, {4'b0, lnk});
  endtask

  task automatic tick();
    @(negedge clk_i) sym_tick_i = 1'b1;
    @(negedge clk_i) sym_tick_i = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, sd passthrough both polarities
    repeat (2) @(negedge clk_i);
    chk_all("R1", 5'h00, 5'h00, 1'b1, 1'b1, 1'b0);
    sd_line_i = 1'b0;
    #1 chk("R1", "sd passthrough", {4'b0, sd_o}, 5'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    sd_line_i = 1'b1;

    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      ctl_local_lpbk_i  = VECS[i].loc;
      ctl_remote_lpbk_i = VECS[i].rem;
      mode_i            = VECS[i].mode;
      tx_en_i           = VECS[i].txen;
      sd_line_i         = VECS[i].sdl;
      tx_sym_i          = VECS[i].tx;
      line_rx_sym_i     = VECS[i].rx;
      sym_tick_i        = 1'b1;
      @(negedge clk_i) sym_tick_i = 1'b0;
      chk_all($sformatf("R2-R7 vec%0d", i), VECS[i].e_pcs, VECS[i].e_line,
              VECS[i].e_sd, VECS[i].e_drv, VECS[i].e_lnk);
    end

    // R8: local request without tick does nothing
    ctl_local_lpbk_i = 1'b1; ctl_remote_lpbk_i = 1'b0; mode_i = 2'b01;
    tx_sym_i = 5'h1B; line_rx_sym_i = 5'h04; sd_line_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk_all("R8 hold", 5'h0B, 5'h14, 1'b0, 1'b1, 1'b0);
    tick();
    chk_all("R3 after tick", 5'h1B, 5'h1B, 1'b1, 1'b0, 1'b1);

    // R4: link drops with transmission, returns after
    tx_en_i = 1'b1;
    #1 chk("R4", "link drop", {4'b0, link10_force_o}, 5'h00);
    @(negedge clk_i) tx_en_i = 1'b0;
    #1 chk("R4", "link back", {4'b0, link10_force_o}, 5'h01);

    // R5 then R8/R6: mode leaves 100BASE-TX without tick
    ctl_local_lpbk_i = 1'b0; ctl_remote_lpbk_i = 1'b1; line_rx_sym_i = 5'h0D;
    sd_line_i = 1'b1;
    tick();
    chk_all("R5", 5'h0D, 5'h0D, 1'b0, 1'b1, 1'b0);
    mode_i = 2'b10; line_rx_sym_i = 5'h12; tx_sym_i = 5'h06;
    repeat (3) @(negedge clk_i);
    chk_all("R8 mode hold", 5'h0D, 5'h0D, 1'b0, 1'b1, 1'b0);
    tick();
    chk_all("R6 exit remote", 5'h12, 5'h06, 1'b1, 1'b1, 1'b0);

    // R1: reset during local loopback
    ctl_local_lpbk_i = 1'b1; ctl_remote_lpbk_i = 1'b0;
    tick();
    chk("R3", "drv off", {4'b0, drv_en_o}, 5'h00);
    @(negedge clk_i) rst_ni = 1'b0;
    #1 chk_all("R1 mid reset", 5'h00, 5'h00, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule